// File: doc/BRIEF.md
# Serial Configuration and Hit-Readout Link

This block is the serial slave through which a multichannel readout front end is configured and interrogated. A host frames each access with an enable line and clocks bits in on a serial clock. The frame carries a leading ignored bit, a direction bit, a seven-bit register address and a 72-bit payload. Reads stream a register back on the serial output one bit per serial clock. Writes load a register once the whole payload has arrived.

Address 0 is the channel interface. A read of it returns the 72-bit hit register, in which every channel that fired since it was last reported stays set. A write to it loads the 72-bit readout-selection register, which picks the channels to be digitised. Addresses 1 to NCFG are plain 72-bit configuration words. They hold settings such as thresholds, gains and polarity purely as bits.

All four serial pins are asynchronous to the system clock. They are resynchronised, and the serial clock edges are found by edge detection. Each serial phase, high and low, must therefore last at least four system clock cycles. The serial pins are plain control wires with no valid/ready handshake: the host owns the pacing, and the block never applies back-pressure.

Top module: `ser_cfg_link`

## Requirements
- R1: After reset the selection register, all configuration words, the hit register and the serial output are all zero.
- R2: A frame exists only while `ser_en_i` is high. While it is low, serial clock edges have no effect and `ser_do_o` is 0.
- R3: Bits are taken on rising serial clock edges. Bit 0 of a frame is ignored. Bit 1 is the direction, where 1 means read and 0 means write. Bits 2 to 8 are the address, MSB first. Bits 9 to 80 are the 72 data bits, MSB first (bit 71 first).
- R4: A write to address 0 loads `chsel_o` with the payload. The first data bit lands in bit 71. The update happens on the 81st rising edge of the frame.
- R5: A read drives its first data bit (bit 71) on the falling serial edge after the 9th rising edge, 8.5 serial periods into the frame. Each later bit follows on the next falling edge, so the host takes read bits on rising edges 10 to 81. Before that first falling edge, the output is 0.
- R6: Each bit of the hit register is set while the matching `hit_i` bit is high. A read of address 0 captures the register after the address is received. On the 81st rising edge it clears only the captured ones; a hit arriving later stays set.
- R7: A write to address k (1..NCFG) stores the payload in `cfg_o[(k-1)*72 +: 72]`. A read of k returns that word.
- R8: A frame whose enable drops before the 81st rising edge changes no register and clears no hit.
- R9: A write to an address above NCFG changes nothing. A read of such an address returns all zeros.
- R10: Rising edges after the 81st in the same frame are ignored. Counting restarts from bit 0 on the next rise of the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_i | input | 1 | Frame enable from the host, high during a frame |
| ser_ck_i | input | 1 | Serial clock from the host |
| ser_di_i | input | 1 | Serial data into the block |
| ser_do_o | output | 1 | Serial read data out of the block |
| hit_i | input | 72 | Per-channel hit flags from the discriminators |
| chsel_o | output | 72 | Readout-selection register |
| cfg_o | output | NCFG*72 | Configuration words, word k-1 at bits (k-1)*72 upward |

## Verification
A serial pin change passes two synchroniser flops and an edge detector, so any state it causes is in place by the third system clock edge after the pin moves. The serial output changes within three system clocks of a falling serial edge. A register write or hit clear lands within three system clocks of the 81st rising edge. The bench holds each serial phase for six system clocks and reads `ser_do_o` on the clock before it raises the serial clock, as a host would. It checks the ports only after dropping enable and waiting eight further clocks, so every check falls well after its result is due.

// File: rtl/ser_cfg_link_pkg.sv
package ser_cfg_link_pkg;
  localparam int DATA_W     = 72;
  localparam int ADDR_W     = 7;
  localparam int HDR_BITS   = 2 + ADDR_W;           // ignored bit, direction, address
  localparam int FRAME_BITS = HDR_BITS + DATA_W;    // 81 rising edges per full frame
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } ser_dir_e;
endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  input  logic ck_pin,
  input  logic di_pin,
  output logic en_s,
  output logic di_s,
  output logic ck_rise,
  output logic ck_fall
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pins_raw;
  logic [NPIN-1:0] pins_s;
  logic            ck_prev;

  assign pins_raw = {en_pin, ck_pin, di_pin};

  generate
    for (genvar g = 0; g < NPIN; g++) begin : g_sync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pins_raw[g]};
      end
      assign pins_s[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev <= 1'b0;
    else        ck_prev <= pins_s[1];
  end

  assign en_s    = pins_s[2];
  assign di_s    = pins_s[0];
  assign ck_rise = pins_s[1] & ~ck_prev;
  assign ck_fall = ~pins_s[1] & ck_prev;
endmodule

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl
  import ser_cfg_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic              di_s,
  input  logic              ck_rise,
  input  logic              ck_fall,
  output logic              hdr_stb,
  output ser_dir_e          hdr_dir,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              data_stb,
  output logic              last_stb,
  output ser_dir_e          dir_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rd_shift
);
  localparam logic [CNT_W-1:0] C_ADR_END = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] C_HDR     = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] C_LAST    = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] C_END     = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] hdr_q;
  logic              rd_act;
  logic              live;

  assign live = en_s && ck_rise && (cnt < C_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en_s)  cnt <= '0;
    else if (live)   cnt <= cnt + CNT_W'(1);
  end

  // direction and the upper address bits collect here; the last address bit comes straight from the pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_q <= '0;
    else if (live && (cnt != '0) && (cnt < C_ADR_END))
      hdr_q <= {hdr_q[ADDR_W-2:0], di_s};
  end

  assign hdr_stb  = live && (cnt == C_ADR_END);
  assign hdr_dir  = ser_dir_e'(hdr_q[ADDR_W-1]);
  assign hdr_addr = {hdr_q[ADDR_W-2:0], di_s};
  assign data_stb = live && (cnt >= C_HDR);
  assign last_stb = live && (cnt == C_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= DIR_WR;
      addr_q <= '0;
    end else if (hdr_stb) begin
      dir_q  <= hdr_dir;
      addr_q <= hdr_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rd_act <= 1'b0;
    else if (!en_s)                      rd_act <= 1'b0;
    else if (hdr_stb && hdr_dir == DIR_RD) rd_act <= 1'b1;
  end

  assign rd_shift = en_s && ck_fall && rd_act;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= C_END); // R10
  AST_RDACT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en_s |=> !rd_act); // R2
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n) !en_s |=> (cnt == '0)); // R10
endmodule

// File: rtl/ser_regbank.sv
module ser_regbank
  import ser_cfg_link_pkg::*;
#(
  parameter int NCFG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic              di_s,
  input  logic [DATA_W-1:0] hit_i,
  input  logic              hdr_stb,
  input  ser_dir_e          hdr_dir,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              data_stb,
  input  logic              last_stb,
  input  ser_dir_e          dir_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              rd_shift,
  output logic              sdo_q,
  output logic [DATA_W-1:0] sel_q,
  output logic [NCFG*DATA_W-1:0] cfg_flat
);
  logic [DATA_W-1:0] cfg_q [NCFG];
  logic [DATA_W-1:0] hit_q;
  logic [DATA_W-1:0] snap_q;
  logic [DATA_W-1:0] rd_sh;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-2:0] wr_sh;
  logic [DATA_W-1:0] wr_word;
  logic              wr_commit;
  logic              rd_done0;

  assign wr_word   = {wr_sh, di_s};
  assign wr_commit = last_stb && (dir_q == DIR_WR);
  assign rd_done0  = last_stb && (dir_q == DIR_RD) && (addr_q == '0);
  assign clr_mask  = rd_done0 ? snap_q : '0;

  always_comb begin
    rd_word = '0;
    if (hdr_addr == '0) rd_word = hit_q;
    for (int i = 0; i < NCFG; i++)
      if (hdr_addr == ADDR_W'(i + 1)) rd_word = cfg_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= (hit_q & ~clr_mask) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      rd_sh  <= '0;
    end else if (hdr_stb && hdr_dir == DIR_RD) begin
      snap_q <= (hdr_addr == '0) ? hit_q : '0;
      rd_sh  <= rd_word;
    end else if (rd_shift) begin
      rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdo_q <= 1'b0;
    else if (!en_s)    sdo_q <= 1'b0;
    else if (rd_shift) sdo_q <= rd_sh[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_sh <= '0;
    else if (data_stb) wr_sh <= wr_word[DATA_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int i = 0; i < NCFG; i++) cfg_q[i] <= '0;
    end else if (wr_commit) begin
      if (addr_q == '0) sel_q <= wr_word;
      for (int i = 0; i < NCFG; i++)
        if (addr_q == ADDR_W'(i + 1)) cfg_q[i] <= wr_word;
    end
  end

  generate
    for (genvar g = 0; g < NCFG; g++) begin : g_flat
      assign cfg_flat[g*DATA_W +: DATA_W] = cfg_q[g];
    end
  endgenerate

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_commit && addr_q == '0) |=> $stable(sel_q)); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(cfg_flat)); // R7
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i != '0) |=> ((hit_q & $past(hit_i)) == $past(hit_i))); // R6
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en_s |=> !sdo_q); // R2
endmodule

// File: rtl/ser_cfg_link.sv
module ser_cfg_link
  import ser_cfg_link_pkg::*;
#(
  parameter int NCFG        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_en_i,
  input  logic                   ser_ck_i,
  input  logic                   ser_di_i,
  output logic                   ser_do_o,
  input  logic [DATA_W-1:0]      hit_i,
  output logic [DATA_W-1:0]      chsel_o,
  output logic [NCFG*DATA_W-1:0] cfg_o
);
  logic              en_s, di_s, ck_rise, ck_fall;
  logic              hdr_stb, data_stb, last_stb, rd_shift;
  ser_dir_e          hdr_dir, dir_q;
  logic [ADDR_W-1:0] hdr_addr, addr_q;

  ser_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .en_pin(ser_en_i), .ck_pin(ser_ck_i), .di_pin(ser_di_i),
    .en_s(en_s), .di_s(di_s), .ck_rise(ck_rise), .ck_fall(ck_fall)
  );

  ser_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .di_s(di_s),
    .ck_rise(ck_rise), .ck_fall(ck_fall),
    .hdr_stb(hdr_stb), .hdr_dir(hdr_dir), .hdr_addr(hdr_addr),
    .data_stb(data_stb), .last_stb(last_stb),
    .dir_q(dir_q), .addr_q(addr_q), .rd_shift(rd_shift)
  );

  ser_regbank #(.NCFG(NCFG)) u_bank (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .di_s(di_s), .hit_i(hit_i),
    .hdr_stb(hdr_stb), .hdr_dir(hdr_dir), .hdr_addr(hdr_addr),
    .data_stb(data_stb), .last_stb(last_stb),
    .dir_q(dir_q), .addr_q(addr_q), .rd_shift(rd_shift),
    .sdo_q(ser_do_o), .sel_q(chsel_o), .cfg_flat(cfg_o)
  );
endmodule

// File: tb/ser_cfg_link_tb_top.sv
module ser_cfg_link_tb_top;
  localparam int NCFG = 4;
  localparam int DW   = 72;
  localparam int HALF = 6;     // system clocks per serial phase
  localparam int NVEC = 8;
  localparam int VW   = 1 + 7 + DW + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ck = 1'b0, di = 1'b0;
  logic do_w;
  logic [DW-1:0] hit = '0;
  logic [DW-1:0] chsel;
  logic [NCFG*DW-1:0] cfg;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [DW-1:0] m_sel;
  logic [DW-1:0] m_cfg [NCFG];

  always #5 clk = ~clk;

  ser_cfg_link #(.NCFG(NCFG)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en_i(en), .ser_ck_i(ck), .ser_di_i(di),
    .ser_do_o(do_w), .hit_i(hit), .chsel_o(chsel), .cfg_o(cfg)
  );

  // {dir, addr, payload, expected read}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b0, 7'd0, 72'hA5_0123_4567_89AB_CDEF, 72'h0},
    {1'b0, 7'd1, 72'h80_0000_0000_0000_0001, 72'h0},
    {1'b0, 7'd4, 72'h3C_FFFF_0000_AAAA_5555, 72'h0},
    {1'b1, 7'd1, 72'h0,                      72'h80_0000_0000_0000_0001},
    {1'b0, 7'd9, 72'hFF_FFFF_FFFF_FFFF_FFFF, 72'h0},
    {1'b1, 7'd9, 72'h0,                      72'h0},
    {1'b1, 7'd4, 72'h0,                      72'h3C_FFFF_0000_AAAA_5555},
    {1'b0, 7'd0, 72'h00_0000_0000_0000_0000, 72'h0}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(req, chsel, m_sel);
    for (int k = 0; k < NCFG; k++) chk(req, cfg[k*DW +: DW], m_cfg[k]);
  endtask

  task automatic frame(input logic dc, input logic dir, input logic [6:0] addr,
                       input logic [DW-1:0] wd, input int nbits,
                       output logic [DW-1:0] rd, output logic pre);
    rd = '0;
    pre = 1'b0;
    @(negedge clk);
    ck = 1'b0;
    en = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i == 0)       di = dc;
      else if (i == 1)  di = dir;
      else if (i < 9)   di = addr[8-i];
      else if (i < 81)  di = wd[80-i];
      else              di = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      if (i == 8) pre = do_w;
      if (i >= 9 && i <= 80) rd[80-i] = do_w;
      @(negedge clk);
      ck = 1'b1;
      repeat (HALF) @(negedge clk);
      ck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_hit(input logic [DW-1:0] pat);
    @(negedge clk);
    hit = pat;
    @(negedge clk);
    hit = '0;
  endtask

  initial begin
    logic [DW-1:0] rd;
    logic pre;
    m_sel = '0;
    for (int k = 0; k < NCFG; k++) m_cfg[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk_regs("R1");
    chk("R1 sdo", {71'b0, do_w}, '0);

    // R2: clock toggling with enable low does nothing
    for (int j = 0; j < 12; j++) begin
      di = 1'b1;
      repeat (HALF) @(negedge clk);
      ck = ~ck;
      chk("R2 idle sdo", {71'b0, do_w}, '0);
    end
    ck = 1'b0;
    repeat (8) @(negedge clk);
    chk_regs("R2");

    // vector table: R3 (ignored bit varies), R4, R7, R9
    for (int v = 0; v < NVEC; v++) begin
      logic vd;
      logic [6:0] va;
      logic [DW-1:0] vw, vx;
      {vd, va, vw, vx} = VEC[v];
      frame(v[0], vd, va, vw, 81, rd, pre);
      if (vd == 1'b0) begin
        if (va == 0) m_sel = vw;
        else if (va <= NCFG) m_cfg[va-1] = vw;
        chk_regs("R3 R4 R7 R9 write");
      end else begin
        chk("R3 R7 R9 read", rd, vx);
      end
    end

    // R5 and R6: hit read with a hit arriving mid-read
    pulse_hit({1'b1, 63'b0, 8'b0000_1000});
    fork
      frame(1'b0, 1'b1, 7'd0, '0, 81, rd, pre);
      begin
        repeat (400) @(negedge clk);
        pulse_hit(72'h1 << 10);
      end
    join
    chk("R5 first bit timing", {71'b0, pre}, '0);
    chk("R5 R6 hit read", rd, {1'b1, 63'b0, 8'b0000_1000});
    frame(1'b1, 1'b1, 7'd0, '0, 81, rd, pre);
    chk("R6 late hit kept", rd, 72'h1 << 10);
    frame(1'b0, 1'b1, 7'd0, '0, 81, rd, pre);
    chk("R6 cleared", rd, '0);

    // R8: aborted write and aborted read
    frame(1'b0, 1'b0, 7'd0, {DW{1'b1}}, 50, rd, pre);
    chk_regs("R8 aborted write");
    frame(1'b1, 1'b0, 7'd2, {DW{1'b1}}, 80, rd, pre);
    chk_regs("R8 write short by one");
    pulse_hit(72'h1 << 5);
    frame(1'b0, 1'b1, 7'd0, '0, 40, rd, pre);
    frame(1'b0, 1'b1, 7'd0, '0, 81, rd, pre);
    chk("R8 hit survives abort", rd, 72'h1 << 5);

    // R10: extra edges after the payload ignored
    frame(1'b0, 1'b0, 7'd0, 72'h5A_F00F_1234_0000_8001, 86, rd, pre);
    m_sel = 72'h5A_F00F_1234_0000_8001;
    chk_regs("R10 extra edges");
    frame(1'b1, 1'b1, 7'd3, '0, 81, rd, pre);
    chk("R10 restart read", rd, m_cfg[2]);
    chk("R2 sdo after frame", {71'b0, do_w}, '0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule